// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a clocked host and an asynchronous 512K x 8 static RAM. The host issues single-beat reads and writes through a request/ready handshake. Each request carries a write flag, a 19-bit address and, for writes, one byte of data. The controller turns each accepted request into a memory cycle whose phases are whole clock counts. Every phase length is a parameter, so the timing margins follow the clock frequency chosen for the chip.

Reads hold select and output enable low for a fixed number of cycles. The returned byte is captured at the end of the read and handed back with a one-clock valid strobe. Writes are write-enable controlled, with output enable held high for the whole cycle. The address is set up before the write strobe falls and held through a recovery cycle after it rises. The bidirectional data bus appears as an output value, an output enable and an input value, and the pad buffer lies outside the block. The controller turns its data drivers on only after the memory's output enable has been high for at least one clock, so the two never drive the bus together.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While reset is applied and after it is released, with no request, chip select, write enable and output enable are high, the data output enable is low, ready is high and read valid is low.
- R2: A read holds chip select and output enable low for exactly RD_CYC (default 3) consecutive clocks. Write enable stays high and the address equals the request address throughout.
- R3: Read data is the memory input value sampled on the last clock of the read. It appears on the read data output while read valid is high for exactly one clock, immediately after chip select rises.
- R4: A write holds chip select low for WR_SETUP+WR_PULSE+WR_RECOV clocks (defaults 1, 2, 1). Write enable stays high for the first WR_SETUP clocks, is low for the next WR_PULSE clocks, and is high again for the last WR_RECOV clocks.
- R5: During a whole write, output enable stays high, the data output enable is high and the data output equals the request's write data.
- R6: The data output enable is never high in a clock in which output enable is low, or in the clock right after one in which output enable was low.
- R7: The memory address changes only on a clock edge where write enable is high both before and after the edge.
- R8: Ready is low from the clock after a request is accepted (request and ready both high at a rising edge) until the cycle ends. A read keeps ready low for RD_CYC clocks and a write for WR_SETUP+WR_PULSE+WR_RECOV clocks. A request is accepted only while idle, so back-to-back cycles are separated by exactly one clock with chip select high.
- R9: Read valid is never raised by a write cycle, and it is raised exactly once per read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 1 | Host request |
| rdy_o | output | 1 | Controller idle and able to accept a request |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 19 | Request address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| rvalid_o | output | 1 | One-clock strobe qualifying rdata_o |
| mem_addr_o | output | 19 | Memory address |
| mem_cs_n_o | output | 1 | Memory chip select, active low |
| mem_we_n_o | output | 1 | Memory write enable, active low |
| mem_oe_n_o | output | 1 | Memory output enable, active low |
| mem_dq_o | output | 8 | Data value for the bus drivers |
| mem_dq_oe_o | output | 1 | Enable for the bus drivers |
| mem_dq_i | input | 8 | Data value seen on the bus |

## Verification
The hardest case to reach is the bus turnaround: a write accepted in the very first idle clock after a read. Only then does the driver enable come up one clock after output enable rises. The bench reaches it by issuing the next request in the same clock that ready returns, so read-to-write, write-to-read and same-type pairs run with the minimum one-clock gap. A bench memory model answers only when select and output enable are low and write enable is high. It latches data on the rising edge of write enable, so any misplaced strobe or address shows up as wrong read-back data.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_WSETUP = 3'd2,
    ST_WPULSE = 3'd3,
    ST_WRECOV = 3'd4
  } cyc_state_e;

  function automatic int unsigned max4(int unsigned a, int unsigned b,
                                       int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned RD_CYC   = 3,
  parameter int unsigned WR_SETUP = 1,
  parameter int unsigned WR_PULSE = 2,
  parameter int unsigned WR_RECOV = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic wr_i,
  output logic rdy_o,
  output logic accept_o,
  output logic sample_o,
  output logic cs_n_o,
  output logic we_n_o,
  output logic oe_n_o,
  output logic dq_oe_o
);
  localparam int unsigned MAXLEN = max4(RD_CYC, WR_SETUP, WR_PULSE, WR_RECOV);
  localparam int unsigned CNT_W  = (MAXLEN > 1) ? $clog2(MAXLEN) : 1;

  cyc_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             cs_n_q, we_n_q, oe_n_q, dq_oe_q;
  logic             last;

  assign rdy_o    = (state_q == ST_IDLE);
  assign accept_o = rdy_o && req_i;
  assign last     = (cnt_q == '0);

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    cnt_en   = 1'b0;
    sample_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        cnt_en = 1'b1;
        if (wr_i) begin
          state_d = ST_WSETUP;
          cnt_d   = CNT_W'(WR_SETUP - 1);
        end else begin
          state_d = ST_READ;
          cnt_d   = CNT_W'(RD_CYC - 1);
        end
      end
      ST_READ: begin
        cnt_en = 1'b1;
        if (last) begin
          state_d  = ST_IDLE;
          sample_o = 1'b1;
        end else cnt_d = cnt_q - 1'b1;
      end
      ST_WSETUP: begin
        cnt_en = 1'b1;
        if (last) begin
          state_d = ST_WPULSE;
          cnt_d   = CNT_W'(WR_PULSE - 1);
        end else cnt_d = cnt_q - 1'b1;
      end
      ST_WPULSE: begin
        cnt_en = 1'b1;
        if (last) begin
          state_d = ST_WRECOV;
          cnt_d   = CNT_W'(WR_RECOV - 1);
        end else cnt_d = cnt_q - 1'b1;
      end
      ST_WRECOV: begin
        cnt_en = 1'b1;
        if (last) state_d = ST_IDLE;
        else      cnt_d   = cnt_q - 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      cs_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
      cs_n_q  <= (state_d == ST_IDLE);
      we_n_q  <= (state_d != ST_WPULSE);
      oe_n_q  <= (state_d != ST_READ);
      dq_oe_q <= (state_d == ST_WSETUP) || (state_d == ST_WPULSE) ||
                 (state_d == ST_WRECOV);
    end
  end

  assign cs_n_o  = cs_n_q;
  assign we_n_o  = we_n_q;
  assign oe_n_o  = oe_n_q;
  assign dq_oe_o = dq_oe_q;
endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              sample_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] dq_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              rvalid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      if (accept_i) begin
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end
      if (sample_i) rdata_q <= dq_i;
      rvalid_q <= sample_i;
    end
  end

  assign mem_addr_o = addr_q;
  assign dq_o       = wdata_q;
  assign rdata_o    = rdata_q;
  assign rvalid_o   = rvalid_q;
endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl #(
  parameter int unsigned ADDR_W   = 19,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned RD_CYC   = 3,
  parameter int unsigned WR_SETUP = 1,
  parameter int unsigned WR_PULSE = 2,
  parameter int unsigned WR_RECOV = 1,
  parameter int unsigned SYNC_FF  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  output logic              rdy_o,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_cs_n_o,
  output logic              mem_we_n_o,
  output logic              mem_oe_n_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);
  logic [SYNC_FF-1:0] rst_sync_q;
  logic               rst_n_int;
  logic               accept, sample;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[SYNC_FF-2:0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[SYNC_FF-1];

  sram_ctrl_fsm #(
    .RD_CYC(RD_CYC), .WR_SETUP(WR_SETUP),
    .WR_PULSE(WR_PULSE), .WR_RECOV(WR_RECOV)
  ) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_int),
    .req_i    (req_i),
    .wr_i     (wr_i),
    .rdy_o    (rdy_o),
    .accept_o (accept),
    .sample_o (sample),
    .cs_n_o   (mem_cs_n_o),
    .we_n_o   (mem_we_n_o),
    .oe_n_o   (mem_oe_n_o),
    .dq_oe_o  (mem_dq_oe_o)
  );

  sram_ctrl_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_int),
    .accept_i   (accept),
    .sample_i   (sample),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .dq_i       (mem_dq_i),
    .mem_addr_o (mem_addr_o),
    .dq_o       (mem_dq_o),
    .rdata_o    (rdata_o),
    .rvalid_o   (rvalid_o)
  );
endmodule

// File: rtl/sram_cycle_ctrl_chk.sv
module sram_cycle_ctrl_chk #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              rdy_o,
  input logic              rvalid_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_cs_n_o,
  input logic              mem_we_n_o,
  input logic              mem_oe_n_o,
  input logic              mem_dq_oe_o
);
  // R1 / R8: idle means the memory is deselected and the bus is released
  a_r1_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |-> (mem_cs_n_o && mem_we_n_o && mem_oe_n_o && !mem_dq_oe_o));

  // R2: output enable low only inside a selected read
  a_r2_read_strobes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_n_o |-> (!mem_cs_n_o && mem_we_n_o && !rdy_o));

  // R3: read valid is a single-clock pulse
  a_r3_rvalid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);

  // R4: write strobe only while selected and driving
  a_r4_we_in_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_n_o |-> (!mem_cs_n_o && mem_dq_oe_o && mem_oe_n_o));

  // R4: after the strobe rises, a recovery clock keeps select low
  a_r4_recovery: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_n_o) |-> (!mem_cs_n_o && mem_dq_oe_o));

  // R6: drivers on only after output enable has been high a full clock
  a_r6_turnaround: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> (mem_oe_n_o && $past(mem_oe_n_o)));

  // R7: address moves only while write enable is high
  a_r7_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mem_addr_o) |-> (mem_we_n_o && $past(mem_we_n_o)));

  // R9: read valid follows a read, never a write
  a_r9_rvalid_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> ($past(!mem_oe_n_o) && mem_cs_n_o));
endmodule

bind sram_cycle_ctrl sram_cycle_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sram_cycle_ctrl_test.sv
`timescale 1ns/1ps
module sram_cycle_ctrl_test;
  localparam int AW = 19;
  localparam int DW = 8;

  typedef struct packed {
    logic          wr;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } cyc_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req, wr, rdy, rvalid;
  logic [AW-1:0] addr, mem_addr;
  logic [DW-1:0] wdata, rdata, mem_dq, mem_dq_in;
  logic          cs_n, we_n, oe_n, dq_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit mon_on = 1'b0;

  cyc_t          cyc_q[$];
  logic [DW-1:0] rd_q[$];
  logic [DW-1:0] ref_mem [int];
  logic [DW-1:0] model_mem [int];
  bit            model_upd = 1'b0;
  int            last_gap = 0;

  always #2.5 clk = ~clk;

  sram_cycle_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .rdy_o(rdy), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid),
    .mem_addr_o(mem_addr), .mem_cs_n_o(cs_n), .mem_we_n_o(we_n),
    .mem_oe_n_o(oe_n), .mem_dq_o(mem_dq), .mem_dq_oe_o(dq_oe),
    .mem_dq_i(mem_dq_in)
  );

  // asynchronous memory model: answers only in read mode, latches on WE rise
  always @(mem_addr or cs_n or oe_n or we_n or model_upd) begin
    if (!cs_n && !oe_n && we_n)
      mem_dq_in = model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)] : 8'h00;
    else
      mem_dq_in = 8'hEE;
  end
  always @(posedge we_n) begin
    if (!cs_n && dq_oe) begin
      model_mem[int'(mem_addr)] = mem_dq;
      model_upd = ~model_upd;
    end
  end

  task automatic check(input bit ok, input string req_tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  // driver: called at a negedge; issues one request and measures busy time
  task automatic issue(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    int busy;
    cyc_t c;
    while (!rdy) @(negedge clk);
    req = 1'b1; wr = w; addr = a; wdata = d;
    c.wr = w; c.addr = a; c.data = d;
    cyc_q.push_back(c);
    if (w) ref_mem[int'(a)] = d;
    else   rd_q.push_back(ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00);
    @(negedge clk);
    req = 1'b0; wr = 1'b0; addr = '1; wdata = 8'h5A;
    busy = 0;
    while (!rdy) begin busy++; @(negedge clk); end
    // R8: ready low for the whole cycle length
    check(busy == (w ? 4 : 3), "R8 busy clocks", busy, w ? 4 : 3);
  endtask

  // monitor: cycle-shape checker on the memory pins plus read scoreboard
  int   cs_len, oe_cnt, we_cnt, pre_we, post_we, gap;
  bit   drv_ok, seen_we, prev_cs_n = 1'b1, prev_oe_n = 1'b1, prev_rv = 1'b0;
  cyc_t cur;
  always @(negedge clk) if (mon_on) begin
    // R6: no driving while or right after output enable is low
    check(!(dq_oe && (!oe_n || !prev_oe_n)), "R6 bus turnaround", {oe_n, prev_oe_n}, 2'b11);
    if (!cs_n) begin
      if (prev_cs_n) begin
        last_gap = gap;
        cs_len = 0; oe_cnt = 0; we_cnt = 0; pre_we = 0; post_we = 0;
        drv_ok = 1'b1; seen_we = 1'b0;
        if (cyc_q.size() == 0) begin
          check(1'b0, "R8 unrequested cycle", 1, 0);
          cur = '0;
        end else cur = cyc_q.pop_front();
      end
      cs_len++;
      if (!oe_n) oe_cnt++;
      if (!we_n) begin we_cnt++; seen_we = 1'b1; end
      else if (!seen_we) pre_we++;
      else post_we++;
      if (cur.wr && !(dq_oe && mem_dq == cur.data)) drv_ok = 1'b0;
      // R2 / R4: address equals the request address in every selected clock
      check(mem_addr == cur.addr, cur.wr ? "R4 write address" : "R2 read address",
            mem_addr, cur.addr);
    end else begin
      if (!prev_cs_n) begin
        gap = 0;
        if (cur.wr) begin
          check(cs_len == 4, "R4 write select length", cs_len, 4);
          check(pre_we == 1 && we_cnt == 2 && post_we == 1, "R4 strobe placement",
                {pre_we[7:0], we_cnt[7:0], post_we[7:0]}, 24'h010201);
          check(oe_cnt == 0 && drv_ok, "R5 write drive", {oe_cnt[7:0], 7'd0, drv_ok}, 16'h0001);
        end else begin
          check(cs_len == 3 && oe_cnt == 3, "R2 read strobe length",
                {cs_len[7:0], oe_cnt[7:0]}, 16'h0303);
          check(we_cnt == 0, "R2 write enable high in read", we_cnt, 0);
        end
      end
      gap++;
    end
    if (rvalid) begin
      check(!prev_rv, "R3 single-clock valid", prev_rv, 0);
      if (rd_q.size() == 0) check(1'b0, "R9 valid without read", 1, 0);
      else begin
        logic [DW-1:0] e;
        e = rd_q.pop_front();
        check(rdata == e, "R3 read data", rdata, e);
      end
    end
    prev_cs_n = cs_n; prev_oe_n = oe_n; prev_rv = rvalid;
  end

  task automatic reset_state(input string tag);
    check(cs_n && we_n && oe_n && !dq_oe && rdy && !rvalid, tag,
          {cs_n, we_n, oe_n, dq_oe, rdy, rvalid}, 6'b111010);
  endtask

  initial begin
    req = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
    rst_n = 1'b0;
    #1;
    repeat (3) @(negedge clk);
    reset_state("R1 during reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    reset_state("R1 after release");
    mon_on = 1'b1;

    // writes to boundary and patterned addresses
    issue(1'b1, 19'h00000, 8'hA5);
    issue(1'b1, 19'h7FFFF, 8'h3C);
    issue(1'b1, 19'h12345, 8'hFF);
    issue(1'b1, 19'h55555, 8'h00);
    // read-back
    issue(1'b0, 19'h00000, 8'h00);
    issue(1'b0, 19'h7FFFF, 8'h00);
    issue(1'b0, 19'h12345, 8'h00);
    issue(1'b0, 19'h55555, 8'h00);
    issue(1'b0, 19'h2AAAA, 8'h00);   // never written
    // R8: back-to-back read then write, gap exactly one idle clock
    issue(1'b0, 19'h12345, 8'h00);
    issue(1'b1, 19'h12345, 8'h96);
    check(last_gap == 1, "R8 read-to-write gap", last_gap, 1);
    issue(1'b0, 19'h12345, 8'h00);
    check(last_gap == 1, "R8 write-to-read gap", last_gap, 1);
    issue(1'b1, 19'h00001, 8'h01);
    issue(1'b1, 19'h00002, 8'h02);
    check(last_gap == 1, "R8 write-to-write gap", last_gap, 1);
    issue(1'b0, 19'h00002, 8'h00);
    issue(1'b0, 19'h00001, 8'h00);
    check(last_gap == 1, "R8 read-to-read gap", last_gap, 1);
    issue(1'b0, 19'h7FFFF, 8'h00);
    repeat (4) @(negedge clk);
    reset_state("R1 idle after traffic");
    // R9: every read returned exactly once, no extra valid strobes
    check(rd_q.size() == 0 && cyc_q.size() == 0, "R9 scoreboard drained",
          rd_q.size() + cyc_q.size(), 0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule